// File: doc/BRIEF.md
# Floppy Head Step Sequencer

This block drives the step and direction lines of a floppy drive head positioner. A request carries a direction, a number of steps and a timing configuration. The timing configuration has a 2-bit rate code, a density select, a reference-clock select, a test strap and a verify flag. The block first holds the direction line for a setup time. It then issues the requested number of fixed-width step pulses, one per step period. After the last period it can run a head-settling delay. It ends with a one-cycle done pulse. Command decoding, track bookkeeping and the data path belong to the surrounding controller.

All durations are counted in system clock cycles. One tick of the nominal 2 MHz reference lasts `TICK_DIV` cycles. `TICKS_PER_US` and `TICKS_PER_MS` give the number of ticks in a microsecond and in a millisecond. When the slow-reference select is set, the block emulates a 1 MHz reference: every phase takes twice as many cycles. The configuration is captured when the request is accepted and stays fixed until done.

Below, M is `TICK_DIV` when `ref_slow_i`=0 and 2·`TICK_DIV` when `ref_slow_i`=1. The request is accepted at clock edge k, and "cycle j" means the state after edge k+j.

Top module: `floppy_step_seq`

## Requirements
- R1: With `test_i`=1, the time from one rising step edge to the next is 3, 6, 10 or 15 ms for `rate_i` = 0, 1, 2 or 3. In cycles this is that many ms times `TICKS_PER_MS`·M.
- R2: With `ref_slow_i`=1, every duration doubles because M becomes 2·`TICK_DIV`. This covers the step period, pulse width, direction setup and settle delay, so the ms rates become 6, 12, 20 and 30.
- R3: With `test_i`=0, the step period is 200 µs (200·`TICKS_PER_US`·M cycles) whatever `rate_i` holds, and no settle delay is run.
- R4: `step_o` stays high for 2 µs when `mfm_i`=1 (double density) and for 4 µs when `mfm_i`=0 (single density), times `TICKS_PER_US`·M cycles.
- R5: `dir_o` takes `dir_i` at acceptance (1 = step in, 0 = step out) and holds it until done. The first rising step edge comes at cycle 12·`TICKS_PER_US`·M.
- R6: With `verify_i`=1 and `test_i`=1, a settle delay of 15·`TICKS_PER_MS`·M cycles follows the last step period before done.
- R7: A step count of zero produces no pulse. Done comes at cycle 15·`TICKS_PER_MS`·M if a settle is due, and at cycle 1 otherwise.
- R8: `busy_o` is high from cycle 0 until the done cycle. A request seen while busy changes no output and no timing.
- R9: After reset, all outputs are 0. `done_o` is high for exactly one cycle, and in that cycle `busy_o` falls. With steps and no settle, done comes at cycle Ls + n·Lper, where Ls is the setup time and Lper the step period.
- R10: All step periods within one request are equal, because the single phase timer is reloaded at every phase boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start request, taken when not busy |
| dir_i | input | 1 | Requested direction, 1 = in |
| count_i | input | CNT_W | Number of steps |
| rate_i | input | 2 | Step rate code |
| mfm_i | input | 1 | 1 = double density, 0 = single density |
| ref_slow_i | input | 1 | 1 = emulate 1 MHz reference |
| test_i | input | 1 | 0 = fast test timing |
| verify_i | input | 1 | Request settle delay after stepping |
| busy_o | output | 1 | Sequence in progress |
| step_o | output | 1 | Step pulse to the drive |
| dir_o | output | 1 | Direction to the drive |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with `TICK_DIV`=1, `TICKS_PER_US`=1 and `TICKS_PER_MS`=10. This shrinks a millisecond to ten cycles, so the full rate table, the doubled slow-reference timing and the settle delay all fit in short runs. The microsecond-scale pulse widths and direction setup stay at distinct small cycle counts (2, 4, 12 and their doubles), so a wrong density or reference choice shows up as an exact cycle mismatch. Random requests mix every configuration bit with step counts from zero to four. Requests are also injected while busy, to show they leave the sequence untouched.

// File: rtl/fhs_pkg.sv
package fhs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_WAIT,
    PH_SETTLE,
    PH_FIN
  } phase_t;

  typedef struct packed {
    logic [1:0] rate;
    logic       mfm;
    logic       slow;
    logic       test;
    logic       verify;
  } step_cfg_t;

  // step period in ms at the nominal reference, per rate code
  function automatic int unsigned rate_ms(input logic [1:0] code);
    case (code)
      2'd0:    return 3;
      2'd1:    return 6;
      2'd2:    return 10;
      default: return 15;
    endcase
  endfunction

endpackage

// File: rtl/fhs_timing.sv
module fhs_timing
  import fhs_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 1,
  parameter int unsigned TICKS_PER_US = 2,
  parameter int unsigned TICKS_PER_MS = 2000,
  parameter int unsigned TW           = 20
) (
  input  step_cfg_t       cfg,
  output logic [TW-1:0]   setup_len,
  output logic [TW-1:0]   pulse_len,
  output logic [TW-1:0]   wait_len,
  output logic [TW-1:0]   settle_len,
  output logic            settle_en
);
  localparam int unsigned SETUP_US  = 12;
  localparam int unsigned FAST_US   = 200;
  localparam int unsigned SETTLE_MS = 15;
  localparam int unsigned PW_MFM_US = 2;
  localparam int unsigned PW_FM_US  = 4;

  int unsigned mult;
  int unsigned per_ticks;
  int unsigned pw_ticks;

  always_comb begin
    mult      = cfg.slow ? 2 * TICK_DIV : TICK_DIV;
    per_ticks = cfg.test ? rate_ms(cfg.rate) * TICKS_PER_MS : FAST_US * TICKS_PER_US;
    pw_ticks  = (cfg.mfm ? PW_MFM_US : PW_FM_US) * TICKS_PER_US;
    setup_len  = TW'(SETUP_US * TICKS_PER_US * mult);
    pulse_len  = TW'(pw_ticks * mult);
    wait_len   = TW'((per_ticks - pw_ticks) * mult);
    settle_len = TW'(SETTLE_MS * TICKS_PER_MS * mult);
    settle_en  = cfg.verify & cfg.test;
  end

endmodule

// File: rtl/fhs_timer.sv
module fhs_timer #(
  parameter int unsigned TW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_len,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_len - 1'b1;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);

  // R10: each phase starts from a fresh full-length count
  a_r10_reload: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_len) - 1'b1));

endmodule

// File: rtl/fhs_stepcount.sv
module fhs_stepcount #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] remaining;

  always_ff @(posedge clk) begin
    if (rst)       remaining <= '0;
    else if (load) remaining <= load_val;
    else if (dec)  remaining <= remaining - 1'b1;
  end

  assign last = (remaining == CW'(1));

  // R7: a further pulse is only taken while more than one step remains
  a_r7_dec_above_one: assert property (@(posedge clk) disable iff (rst)
    dec |-> (remaining > CW'(1)));

endmodule

// File: rtl/floppy_step_seq.sv
module floppy_step_seq
  import fhs_pkg::*;
#(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned TICK_DIV     = 1,
  parameter int unsigned TICKS_PER_US = 2,
  parameter int unsigned TICKS_PER_MS = 2000,
  parameter int unsigned TW           = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       rate_i,
  input  logic             mfm_i,
  input  logic             ref_slow_i,
  input  logic             test_i,
  input  logic             verify_i,
  output logic             busy_o,
  output logic             step_o,
  output logic             dir_o,
  output logic             done_o
);
  phase_t    ph, ph_nxt;
  step_cfg_t cfg_in, cfg_q, cfg_use;

  logic [TW-1:0] setup_len, pulse_len, wait_len, settle_len, tmr_len;
  logic          settle_en, expire, last_step, tmr_load, cnt_load, cnt_dec;

  assign cfg_in  = '{rate: rate_i, mfm: mfm_i, slow: ref_slow_i,
                     test: test_i, verify: verify_i};
  assign cfg_use = (ph == PH_IDLE) ? cfg_in : cfg_q;

  fhs_timing #(
    .TICK_DIV(TICK_DIV), .TICKS_PER_US(TICKS_PER_US),
    .TICKS_PER_MS(TICKS_PER_MS), .TW(TW)
  ) u_timing (
    .cfg(cfg_use), .setup_len(setup_len), .pulse_len(pulse_len),
    .wait_len(wait_len), .settle_len(settle_len), .settle_en(settle_en)
  );

  fhs_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_len(tmr_len), .expire(expire)
  );

  fhs_stepcount #(.CW(CNT_W)) u_count (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(count_i),
    .dec(cnt_dec), .last(last_step)
  );

  always_comb begin
    ph_nxt = ph;
    case (ph)
      PH_IDLE: if (req_i) begin
        if (count_i != '0)  ph_nxt = PH_SETUP;
        else if (settle_en) ph_nxt = PH_SETTLE;
        else                ph_nxt = PH_FIN;
      end
      PH_SETUP:  if (expire) ph_nxt = PH_PULSE;
      PH_PULSE:  if (expire) ph_nxt = PH_WAIT;
      PH_WAIT:   if (expire) begin
        if (!last_step)     ph_nxt = PH_PULSE;
        else if (settle_en) ph_nxt = PH_SETTLE;
        else                ph_nxt = PH_IDLE;
      end
      PH_SETTLE: if (expire) ph_nxt = PH_IDLE;
      PH_FIN:    ph_nxt = PH_IDLE;
      default:   ph_nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (ph_nxt != ph);
    case (ph_nxt)
      PH_SETUP:  tmr_len = setup_len;
      PH_PULSE:  tmr_len = pulse_len;
      PH_WAIT:   tmr_len = wait_len;
      PH_SETTLE: tmr_len = settle_len;
      default:   tmr_len = TW'(1);
    endcase
    cnt_load = (ph == PH_IDLE) && req_i;
    cnt_dec  = (ph == PH_WAIT) && (ph_nxt == PH_PULSE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cfg_q  <= '0;
      busy_o <= 1'b0;
      step_o <= 1'b0;
      dir_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      ph     <= ph_nxt;
      busy_o <= (ph_nxt != PH_IDLE);
      step_o <= (ph_nxt == PH_PULSE);
      done_o <= (ph != PH_IDLE) && (ph_nxt == PH_IDLE);
      if (cnt_load) begin
        cfg_q <= cfg_in;
        dir_o <= dir_i;
      end
    end
  end

  // R5: direction is frozen for the whole sequence
  a_r5_dir_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(dir_o));

  // R8: no step pulse outside a busy sequence
  a_r8_step_in_busy: assert property (@(posedge clk) disable iff (rst)
    step_o |-> busy_o);

  // R9: done is a single cycle and coincides with busy falling
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r9_done_busy_fall: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: tb/test_floppy_step_seq.sv
`timescale 1ns/1ps
module test_floppy_step_seq;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned TDIV  = 1;
  localparam int unsigned TUS   = 1;
  localparam int unsigned TMS   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_i = 1'b0, dir_i = 1'b0, mfm_i = 1'b0, ref_slow_i = 1'b0;
  logic test_i = 1'b0, verify_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic [1:0] rate_i = '0;
  logic busy_o, step_o, dir_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  floppy_step_seq #(
    .CNT_W(CNT_W), .TICK_DIV(TDIV), .TICKS_PER_US(TUS),
    .TICKS_PER_MS(TMS), .TW(20)
  ) i_floppy_step_seq (
    .clk(clk), .rst(rst), .req_i(req_i), .dir_i(dir_i), .count_i(count_i),
    .rate_i(rate_i), .mfm_i(mfm_i), .ref_slow_i(ref_slow_i), .test_i(test_i),
    .verify_i(verify_i), .busy_o(busy_o), .step_o(step_o), .dir_o(dir_o),
    .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mulf(input bit slow);
    return slow ? 2 * TDIV : TDIV;
  endfunction
  function automatic int e_setup(input bit slow);
    return 12 * TUS * mulf(slow);
  endfunction
  function automatic int e_pulse(input bit mfm, input bit slow);
    return (mfm ? 2 : 4) * TUS * mulf(slow);
  endfunction
  function automatic int e_period(input bit [1:0] r, input bit test, input bit slow);
    int ms;
    case (r)
      2'd0: ms = 3;
      2'd1: ms = 6;
      2'd2: ms = 10;
      default: ms = 15;
    endcase
    return test ? ms * TMS * mulf(slow) : 200 * TUS * mulf(slow);
  endfunction
  function automatic int e_settle(input bit ver, input bit test, input bit slow);
    return (ver && test) ? 15 * TMS * mulf(slow) : 0;
  endfunction

  task automatic run_cmd(input bit d, input int n, input bit [1:0] r, input bit mfm,
                         input bit slow, input bit test, input bit ver, input bit poke);
    int ls, lp, lper, lset, dexp, limit;
    int rises, first_rise, last_rise, bad_int, bad_w, bad_busy, bad_dir, done_j;
    bit prev;
    string ptag;
    ls   = e_setup(slow);
    lp   = e_pulse(mfm, slow);
    lper = e_period(r, test, slow);
    lset = e_settle(ver, test, slow);
    if (n == 0) dexp = (lset > 0) ? lset : 1;
    else        dexp = ls + n * lper + lset;
    limit = dexp + 50;
    ptag = test ? (slow ? "R1 R2 R10" : "R1 R10") : (slow ? "R3 R2 R10" : "R3 R10");

    @(negedge clk);
    req_i = 1'b1; dir_i = d; count_i = CNT_W'(n); rate_i = r; mfm_i = mfm;
    ref_slow_i = slow; test_i = test; verify_i = ver;
    @(negedge clk);
    req_i = 1'b0;
    rises = 0; first_rise = -1; last_rise = -1; bad_int = 0; bad_w = 0;
    bad_busy = 0; bad_dir = 0; done_j = -1; prev = 1'b0;
    for (int j = 0; j <= limit; j++) begin
      if (poke && j == 3) req_i = 1'b0;
      if (step_o && !prev) begin
        rises++;
        if (first_rise < 0) first_rise = j;
        else if (j - last_rise != lper) bad_int++;
        last_rise = j;
      end
      if (!step_o && prev && (j - last_rise != lp)) bad_w++;
      prev = step_o;
      if (done_o) begin
        done_j = j;
        break;
      end
      if (!busy_o) bad_busy++;
      if (dir_o !== d) bad_dir++;
      if (poke && j == 2) begin
        req_i = 1'b1; dir_i = ~d; count_i = CNT_W'(7); rate_i = ~r;
        mfm_i = ~mfm; ref_slow_i = ~slow; verify_i = ~ver;
      end
      @(negedge clk);
    end
    req_i = 1'b0;
    check(rises == n, (n == 0) ? "R7 pulse count" : "R8 pulse count", rises, n);
    if (n > 0) begin
      check(first_rise == ls, "R5 first step", first_rise, ls);
      check(bad_int == 0, ptag, bad_int, 0);
      check(bad_w == 0, "R4 pulse width", bad_w, 0);
    end
    check(done_j == dexp,
          (n == 0) ? "R7 done time" : (lset > 0 ? "R6 done time" : "R9 done time"),
          done_j, dexp);
    check(bad_busy == 0, "R8 busy span", bad_busy, 0);
    check(bad_dir == 0, "R5 dir hold", bad_dir, 0);
    @(negedge clk);
    check(!done_o && !busy_o, "R9 done width", int'(done_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !step_o && !dir_o && !done_o, "R9 reset state",
          int'({busy_o, step_o, dir_o, done_o}), 0);

    // R1: each rate code, nominal reference
    for (int r = 0; r < 4; r++) run_cmd(1'b1, 2, 2'(r), 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    // R2: each rate code, slow reference
    for (int r = 0; r < 4; r++) run_cmd(1'b0, 2, 2'(r), 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    // R3: test strap low, rate ignored, verify gives no settle
    run_cmd(1'b1, 3, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_cmd(1'b0, 1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    // R6: settle after stepping
    run_cmd(1'b1, 1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_cmd(1'b1, 2, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    // R7: zero steps with and without settle
    run_cmd(1'b1, 0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_cmd(1'b0, 0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_cmd(1'b0, 0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    // R8: requests while busy are ignored
    run_cmd(1'b1, 3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    run_cmd(1'b0, 0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);

    for (int k = 0; k < 30; k++) begin
      bit [31:0] v;
      v = $urandom;
      run_cmd(v[0], int'(v[10:8] % 5), v[2:1], v[3], v[4], v[5], v[6], v[7]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule